// File: doc/BRIEF.md
# Context-Tagged Translation Cache

This block is a small, fully associative cache of address translations. Each entry holds a virtual page number, a physical frame number and a 12-bit context label. A lookup hits only when the page number matches and the entry's label equals the current context. Because of this, entries that belong to several address spaces can stay resident at once. A reload of the page-table base register then does not have to empty the cache.

The current context comes from two sources. One bit of a control word switches tagging on or off. When tagging is on, the low 12 bits of the most recently written base-register value give the context; when it is off, the context is zero. A lookup returns its answer one cycle later. On a miss, the block raises a request to an external page walker. The walker's answer is written into the cache, and that same answer is also returned as a hit. Lookups made while a request is outstanding are still answered. If a walker reply and a lookup arrive in the same cycle, the reply takes the response slot.

Top module: `ctx_tlb`

## Requirements
- R1: After a synchronous reset, every entry is invalid, `rsp_valid` and `fill_req` are 0, the base value is 0 and the replacement pointer is at entry 0.
- R2: Tagging is on exactly when bit 17 of `ctl_word` is 1, and the other bits of `ctl_word` have no effect. With tagging off, the current context is 0x000. With tagging on, it is bits 11:0 of the last value written to the base register.
- R3: A lookup presented with `lk_valid` produces `rsp_valid` one cycle later. `rsp_hit` is 1 exactly when a valid entry has the same page number and a label equal to the current context, and in that case `rsp_pfn` carries that entry's frame. On a miss, `rsp_pfn` is 0.
- R4: A miss with no request outstanding answers `rsp_hit`=0 and, in the same cycle, raises `fill_req` with `fill_vpn` set to the missed page. Both hold steady until `fill_ack` is seen.
- R5: In a cycle with `fill_req` and `fill_ack` both high, an entry is written with `fill_vpn`, `fill_pfn` and the current context as its label. In the following cycle, `rsp_valid`=1, `rsp_hit`=1, `rsp_pfn` equals that `fill_pfn`, and `fill_req` is 0.
- R6: An entry whose label differs from the current context does not hit, but it is kept. It hits again once its context becomes current.
- R7: A base-register write made while tagging is off invalidates every entry.
- R8: A base-register write made while tagging is on changes only the current context and invalidates nothing.
- R9: The entry written by a fill is the lowest-numbered invalid entry, if one exists. Otherwise it is the entry named by a round-robin pointer, which then advances by one and wraps from 7 to 0. The cache holds 8 entries.
- R10: While a request is outstanding, lookups are still answered. A further miss reports `rsp_hit`=0 and leaves `fill_req` and `fill_vpn` unchanged.
- R11: When a lookup and a walker reply arrive in the same cycle, the reply wins. The next response carries the reply's frame, and the lookup gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_word | input | 32 | Control word; bit 17 enables context tagging |
| base_wr_en | input | 1 | Write strobe for the page-table base register |
| base_wr_data | input | 32 | New base-register value; bits 11:0 are the context |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to look up |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_pfn | output | 20 | Physical frame of the hit |
| fill_req | output | 1 | Request to the page walker |
| fill_vpn | output | 20 | Page the walker must resolve |
| fill_ack | input | 1 | Walker reply strobe |
| fill_pfn | input | 20 | Frame returned by the walker |

## Verification
The bench keeps a reference model of the entries, labels and pointer, and it exercises each context source in turn. These sources are tagging off with a nonzero base, tagging on, and tagging toggled without any base write. A design that ignored the enable bit, or that flushed on every base write, would miss on a page that was filled earlier under another context and should hit again. The bench fills all eight entries and then refills evicted pages, which exposes a pointer that never advances or that overwrites a free slot. It also sends lookups while a fill is pending and in the very cycle of the walker reply. A design that gave the lookup priority, or that restarted the request on a second miss, would return the wrong frame or a changed `fill_vpn`.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;

    localparam int VPN_W = 20;
    localparam int PFN_W = 20;
    localparam int CTX_W = 12;
    localparam int REG_W = 32;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PFN_W-1:0] pfn_t;
    typedef logic [CTX_W-1:0] ctx_t;

    typedef struct packed {
        vpn_t vpn;
        ctx_t ctx;
        pfn_t pfn;
    } tlb_ent_t;

    typedef struct packed {
        logic valid;
        logic hit;
        pfn_t pfn;
    } tlb_rsp_t;

    function automatic ctx_t pick_ctx(input logic tag_on, input ctx_t base_ctx);
        return tag_on ? base_ctx : '0;
    endfunction

endpackage

// File: rtl/ctx_tlb_ctx.sv
module ctx_tlb_ctx
    import ctx_tlb_pkg::*;
#(
    parameter int TAG_EN_BIT = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] ctl_word,
    input  logic             base_wr_en,
    input  logic [REG_W-1:0] base_wr_data,
    output ctx_t             cur_ctx,
    output logic             flush_all
);

    ctx_t base_q;
    logic tag_on;
    logic ctl_unused;
    logic base_unused;

    assign tag_on      = ctl_word[TAG_EN_BIT];
    assign ctl_unused  = ^ctl_word;
    assign base_unused = ^base_wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (base_wr_en) begin
            base_q <= base_wr_data[CTX_W-1:0];
        end
    end

    assign cur_ctx   = pick_ctx(tag_on, base_q);
    assign flush_all = base_wr_en & ~tag_on;

    // R8: a write with tagging on makes its low bits the context
    a_r8_ctx_follows_write: assert property (@(posedge clk) disable iff (rst)
        base_wr_en && tag_on |=> tag_on |-> (cur_ctx == $past(base_wr_data[CTX_W-1:0])));

endmodule

// File: rtl/ctx_tlb_victim.sv
module ctx_tlb_victim #(
    parameter int N     = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     valid,
    input  logic             fill_we,
    output logic [IDX_W-1:0] victim
);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] first_free;
    logic             any_free;

    always_comb begin
        first_free = '0;
        any_free   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                first_free = IDX_W'(i);
                any_free   = 1'b1;
            end
        end
    end

    assign victim = any_free ? first_free : ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (fill_we && !any_free) begin
            ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // R9: a free slot is always preferred over a live entry
    a_r9_prefer_free: assert property (@(posedge clk) disable iff (rst)
        fill_we && !(&valid) |-> !valid[victim]);

    // R9: the pointer moves only when a full array is refilled
    a_r9_ptr_moves: assert property (@(posedge clk) disable iff (rst)
        fill_we && (&valid) |=> ptr_q != $past(ptr_q));

endmodule

// File: rtl/ctx_tlb_array.sv
module ctx_tlb_array
    import ctx_tlb_pkg::*;
#(
    parameter int N     = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_idx,
    input  tlb_ent_t         fill_ent,
    input  vpn_t             lk_vpn,
    input  ctx_t             cur_ctx,
    output logic [N-1:0]     valid,
    output logic             hit,
    output pfn_t             hit_pfn
);

    tlb_ent_t     ent_q [N];
    logic [N-1:0] valid_q;
    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_match
        assign match[g] = valid_q[g] && (ent_q[g].vpn == lk_vpn) && (ent_q[g].ctx == cur_ctx);
    end

    always_comb begin
        hit_pfn = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) hit_pfn = hit_pfn | ent_q[i].pfn;
        end
    end

    assign hit   = |match;
    assign valid = valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int i = 0; i < N; i++) ent_q[i] <= '0;
        end else begin
            if (flush) valid_q <= '0;
            if (fill_we) begin
                valid_q[fill_idx] <= 1'b1;
                ent_q[fill_idx]   <= fill_ent;
            end
        end
    end

    // R7: an untagged base write leaves nothing valid
    a_r7_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush && !fill_we |=> valid_q == '0);

    // R5: a written entry is valid afterwards
    a_r5_fill_sets_valid: assert property (@(posedge clk) disable iff (rst)
        fill_we |=> valid_q[$past(fill_idx)]);

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
    import ctx_tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int TAG_EN_BIT  = 17,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] ctl_word,
    input  logic             base_wr_en,
    input  logic [REG_W-1:0] base_wr_data,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PFN_W-1:0] rsp_pfn,
    output logic             fill_req,
    output logic [VPN_W-1:0] fill_vpn,
    input  logic             fill_ack,
    input  logic [PFN_W-1:0] fill_pfn
);

    ctx_t                   cur_ctx;
    logic                   flush_all;
    logic [NUM_ENTRIES-1:0] valid;
    logic                   arr_hit;
    pfn_t                   arr_pfn;
    logic [IDX_W-1:0]       victim;
    logic                   fill_take;
    tlb_ent_t               new_ent;
    tlb_rsp_t               rsp_q;
    logic                   req_q;
    vpn_t                   req_vpn_q;

    assign fill_take = req_q && fill_ack;
    assign new_ent   = '{vpn: req_vpn_q, ctx: cur_ctx, pfn: fill_pfn};

    ctx_tlb_ctx #(.TAG_EN_BIT(TAG_EN_BIT)) u_ctx (
        .clk          (clk),
        .rst          (rst),
        .ctl_word     (ctl_word),
        .base_wr_en   (base_wr_en),
        .base_wr_data (base_wr_data),
        .cur_ctx      (cur_ctx),
        .flush_all    (flush_all)
    );

    ctx_tlb_victim #(.N(NUM_ENTRIES)) u_victim (
        .clk     (clk),
        .rst     (rst),
        .valid   (valid),
        .fill_we (fill_take),
        .victim  (victim)
    );

    ctx_tlb_array #(.N(NUM_ENTRIES)) u_array (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush_all),
        .fill_we  (fill_take),
        .fill_idx (victim),
        .fill_ent (new_ent),
        .lk_vpn   (lk_vpn),
        .cur_ctx  (cur_ctx),
        .valid    (valid),
        .hit      (arr_hit),
        .hit_pfn  (arr_pfn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q     <= '0;
            req_q     <= 1'b0;
            req_vpn_q <= '0;
        end else if (fill_take) begin
            rsp_q <= '{valid: 1'b1, hit: 1'b1, pfn: fill_pfn};
            req_q <= 1'b0;
        end else if (lk_valid) begin
            rsp_q <= '{valid: 1'b1, hit: arr_hit, pfn: arr_hit ? arr_pfn : '0};
            if (!arr_hit && !req_q) begin
                req_q     <= 1'b1;
                req_vpn_q <= lk_vpn;
            end
        end else begin
            rsp_q <= '0;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_pfn   = rsp_q.pfn;
    assign fill_req  = req_q;
    assign fill_vpn  = req_vpn_q;

    // R3: a hit is only ever reported inside a response
    a_r3_hit_in_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);

    // R4: a fresh miss starts a request for the missed page
    a_r4_miss_starts_req: assert property (@(posedge clk) disable iff (rst)
        lk_valid && !fill_req && !arr_hit |=> fill_req && !rsp_hit && fill_vpn == $past(lk_vpn));

    // R4: the request holds until the walker answers
    a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
        fill_req && !fill_ack |=> fill_req && $stable(fill_vpn));

    // R5 and R11: the walker reply owns the next response
    a_r5_fill_rsp: assert property (@(posedge clk) disable iff (rst)
        fill_req && fill_ack |=> rsp_valid && rsp_hit && !fill_req && rsp_pfn == $past(fill_pfn));

endmodule

// File: tb/ctx_tlb_test.sv
module ctx_tlb_test;

    localparam int ENT = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ctl_word = 32'h0;
    logic        base_wr_en = 1'b0;
    logic [31:0] base_wr_data = 32'h0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = 20'h0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [19:0] rsp_pfn;
    logic        fill_req;
    logic [19:0] fill_vpn;
    logic        fill_ack = 1'b0;
    logic [19:0] fill_pfn = 20'h0;

    int n_chk = 0;
    int n_bad = 0;

    logic        m_valid [ENT];
    logic [19:0] m_vpn   [ENT];
    logic [11:0] m_ctx   [ENT];
    logic [19:0] m_pfn   [ENT];
    int          m_ptr;
    logic        m_en;
    logic [31:0] m_base;

    always #5 clk = ~clk;

    ctx_tlb uut (
        .clk          (clk),
        .rst          (rst),
        .ctl_word     (ctl_word),
        .base_wr_en   (base_wr_en),
        .base_wr_data (base_wr_data),
        .lk_valid     (lk_valid),
        .lk_vpn       (lk_vpn),
        .rsp_valid    (rsp_valid),
        .rsp_hit      (rsp_hit),
        .rsp_pfn      (rsp_pfn),
        .fill_req     (fill_req),
        .fill_vpn     (fill_vpn),
        .fill_ack     (fill_ack),
        .fill_pfn     (fill_pfn)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] m_cur();
        return m_en ? m_base[11:0] : 12'h000;
    endfunction

    function automatic logic [19:0] mkpfn(input logic [19:0] v, input logic [11:0] c);
        return v ^ {8'h00, c} ^ 20'hA5000;
    endfunction

    task automatic m_lookup(input logic [19:0] v, output logic h, output logic [19:0] p);
        h = 1'b0;
        p = 20'h0;
        for (int i = 0; i < ENT; i++) begin
            if (m_valid[i] && m_vpn[i] == v && m_ctx[i] == m_cur()) begin
                h = 1'b1;
                p = m_pfn[i];
            end
        end
    endtask

    task automatic m_fill(input logic [19:0] v, input logic [19:0] p);
        int idx = -1;
        for (int i = ENT - 1; i >= 0; i--) if (!m_valid[i]) idx = i;
        if (idx < 0) begin
            idx = m_ptr;
            m_ptr = (m_ptr + 1) % ENT;
        end
        m_valid[idx] = 1'b1;
        m_vpn[idx]   = v;
        m_ctx[idx]   = m_cur();
        m_pfn[idx]   = p;
    endtask

    task automatic set_tag(input logic en);
        @(negedge clk);
        ctl_word = en ? 32'h0002_0000 : 32'hFFFD_FFFF;
        m_en = en;
    endtask

    task automatic base_write(input logic [31:0] val);
        @(negedge clk);
        base_wr_en   = 1'b1;
        base_wr_data = val;
        @(negedge clk);
        base_wr_en = 1'b0;
        if (!m_en) for (int i = 0; i < ENT; i++) m_valid[i] = 1'b0;
        m_base = val;
    endtask

    task automatic access(input string req, input logic [19:0] v, output logic got_hit);
        logic        eh;
        logic [19:0] ep;
        logic [11:0] c;
        m_lookup(v, eh, ep);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vpn   = v;
        @(negedge clk);
        lk_valid = 1'b0;
        got_hit  = rsp_hit;
        chk(req, 32'(rsp_valid), 32'h1);
        chk(req, 32'(rsp_hit), 32'(eh));
        if (eh) begin
            chk(req, 32'(rsp_pfn), 32'(ep));
        end else begin
            chk("R4", 32'(fill_req), 32'h1);
            chk("R4", 32'(fill_vpn), 32'(v));
            repeat (2) begin
                @(negedge clk);
                chk("R4", 32'(fill_req), 32'h1);
                chk("R4", 32'(fill_vpn), 32'(v));
            end
            c        = m_cur();
            fill_ack = 1'b1;
            fill_pfn = mkpfn(v, c);
            @(negedge clk);
            fill_ack = 1'b0;
            chk("R5", 32'(rsp_valid), 32'h1);
            chk("R5", 32'(rsp_hit), 32'h1);
            chk("R5", 32'(rsp_pfn), 32'(mkpfn(v, c)));
            chk("R5", 32'(fill_req), 32'h0);
            m_fill(v, mkpfn(v, c));
        end
    endtask

    task automatic t_reset();
        logic h;
        chk("R1", 32'(rsp_valid), 32'h0);
        chk("R1", 32'(fill_req), 32'h0);
        access("R1", 20'h00000, h);
        chk("R1", 32'(h), 32'h0);
    endtask

    task automatic t_untagged();
        logic h;
        set_tag(1'b0);
        base_write(32'h0000_0ABC);
        access("R2", 20'h12345, h);
        chk("R3", 32'(h), 32'h0);
        access("R2", 20'h12345, h);
        chk("R3", 32'(h), 32'h1);
        access("R3", 20'h00077, h);
        access("R3", 20'h00077, h);
        chk("R3", 32'(h), 32'h1);
    endtask

    task automatic t_flush();
        logic h;
        base_write(32'h0000_1000);
        access("R7", 20'h12345, h);
        chk("R7", 32'(h), 32'h0);
        access("R7", 20'h00077, h);
        chk("R7", 32'(h), 32'h0);
    endtask

    task automatic t_tagged();
        logic h;
        set_tag(1'b1);
        access("R2", 20'h12345, h);
        chk("R2", 32'(h), 32'h1);
        base_write(32'h0000_2005);
        access("R6", 20'h12345, h);
        chk("R6", 32'(h), 32'h0);
        base_write(32'h0000_300A);
        access("R6", 20'h12345, h);
        chk("R6", 32'(h), 32'h0);
        base_write(32'h0000_4005);
        access("R8", 20'h12345, h);
        chk("R8", 32'(h), 32'h1);
        base_write(32'h0000_5000);
        access("R8", 20'h12345, h);
        chk("R8", 32'(h), 32'h1);
    endtask

    task automatic t_toggle();
        logic h;
        base_write(32'h0000_600A);
        access("R2", 20'h12345, h);
        chk("R2", 32'(h), 32'h1);
        set_tag(1'b0);
        access("R2", 20'h12345, h);
        chk("R2", 32'(h), 32'h1);
        set_tag(1'b1);
        access("R2", 20'h12345, h);
        chk("R2", 32'(h), 32'h1);
    endtask

    task automatic t_pending();
        logic        eh;
        logic [19:0] ep;
        logic [11:0] c;
        c = m_cur();
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vpn   = 20'h0BEEF;
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R4", 32'(rsp_hit), 32'h0);
        chk("R4", 32'(fill_req), 32'h1);
        m_lookup(20'h12345, eh, ep);
        lk_valid = 1'b1;
        lk_vpn   = 20'h12345;
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R10", 32'(rsp_valid), 32'h1);
        chk("R10", 32'(rsp_hit), 32'(eh));
        chk("R10", 32'(rsp_pfn), 32'(ep));
        lk_valid = 1'b1;
        lk_vpn   = 20'h0CAFE;
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R10", 32'(rsp_hit), 32'h0);
        chk("R10", 32'(fill_req), 32'h1);
        chk("R10", 32'(fill_vpn), 32'h0BEEF);
        fill_ack = 1'b1;
        fill_pfn = mkpfn(20'h0BEEF, c);
        lk_valid = 1'b1;
        lk_vpn   = 20'h12345;
        @(negedge clk);
        fill_ack = 1'b0;
        lk_valid = 1'b0;
        chk("R11", 32'(rsp_valid), 32'h1);
        chk("R11", 32'(rsp_pfn), 32'(mkpfn(20'h0BEEF, c)));
        @(negedge clk);
        chk("R11", 32'(rsp_valid), 32'h0);
        m_fill(20'h0BEEF, mkpfn(20'h0BEEF, c));
    endtask

    task automatic t_replace();
        logic h;
        set_tag(1'b0);
        base_write(32'h0);
        for (int k = 0; k < ENT; k++) begin
            access("R9", 20'h00100 + 20'(k), h);
            chk("R9", 32'(h), 32'h0);
        end
        for (int k = 0; k < ENT; k++) begin
            access("R9", 20'h00100 + 20'(k), h);
            chk("R9", 32'(h), 32'h1);
        end
        access("R9", 20'h00108, h);
        access("R9", 20'h00100, h);
        chk("R9", 32'(h), 32'h0);
        access("R9", 20'h00102, h);
        chk("R9", 32'(h), 32'h1);
        access("R9", 20'h00101, h);
        chk("R9", 32'(h), 32'h0);
        access("R9", 20'h00108, h);
        chk("R9", 32'(h), 32'h1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < ENT; i++) begin
            m_valid[i] = 1'b0;
            m_vpn[i]   = 20'h0;
            m_ctx[i]   = 12'h0;
            m_pfn[i]   = 20'h0;
        end
        m_ptr  = 0;
        m_en   = 1'b0;
        m_base = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_untagged();
        t_flush();
        t_tagged();
        t_toggle();
        t_pending();
        t_replace();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule